// File: doc/BRIEF.md
# Byte-Serial Wide-Word ALU

This block is an arithmetic and logic coprocessor that hangs off an 8-bit processor bus. It handles 22-bit operands in three passes of one byte each. The lowest byte goes first and the top byte, which has only six valid bits, goes last. The processor writes one byte of each operand into two input latches, using a decoded device-select code for each operand. It then reads the segment result back on the same bus. A carry or borrow flag holds the arithmetic state from one segment to the next, so a whole 22-bit add or subtract is built from three byte operations.

A 6-bit function code chooses the operation. Writing that code starts a new word: the segment counter and the carry flag both return to zero. Every bus input passes through one register stage before it takes effect. A result therefore appears on the read-data port on the second rising clock edge after the read strobe is presented. The processor must hold each select for exactly one clock; a select held longer acts again on each clock it is held.

Top module: `seg_alu`

## Requirements
- R1: After reset the read-data output is 0, both operand latches are 0, the segment counter is 0, the carry flag is clear, and the function code is 0.
- R2: With the write line high, select code 1 stores the data byte in the operand-A latch and select code 2 stores it in the operand-B latch.
- R3: With the write line low, select codes 1, 2 and 4 change no latch and no function code.
- R4: Every bus input is registered once before it is used. A result read with select 3 shows on the read-data output at the second rising edge after the strobe, and the old value stays there after the first edge.
- R5: With the write line high, select code 4 loads data bits 5:0 as the function code and clears the segment counter and the carry flag.
- R6: Function 0x01 adds A, B and the carry flag. The carry out of each segment feeds the next, so three reads give the 22-bit sum modulo 2^22.
- R7: Function 0x02 subtracts B and the borrow flag from A. The borrow chains between segments, so three reads give the 22-bit difference modulo 2^22.
- R8: Functions 0x10 AND, 0x11 OR, 0x12 XOR and 0x13 NOT A work bitwise on each byte. They take no input from the carry flag and leave it clear.
- R9: Any other function code gives a result byte of 0.
- R10: A read with the write line low and select code 3 returns the current segment's result and moves the counter 0, 1, 2 and back to 0. When the counter wraps, the carry flag clears.
- R11: In segment 2, result bits 7:6 are forced to 0, so nothing past bit 21 is ever visible.
- R12: The read-data output changes only on a result read and holds its value through all other bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | High for a write cycle, low for a read cycle |
| bus_sel | input | 4 | Decoded device-select code; 0 means idle |
| bus_din | input | 8 | Data written by the processor |
| bus_dout | output | 8 | Segment result returned to the processor |

## Verification
On every clock, the assertions check several rules. A read-line strobe never alters the latches or the function code. A function write leaves the counter and carry at zero. The counter stays in range and steps by one on each result read. The top segment's result never shows bits above bit 21. A logic function always leaves the flag clear, and the output holds between reads. Only the bench scenarios can show that full 22-bit sums and differences are correct across all three segments, with the carry and borrow rippling through. They also show that a carry out of the top segment does not leak into the next word, and that results arrive exactly two edges after the strobe.

// File: rtl/seg_alu.sv
module seg_alu #(
  parameter int DW    = 8,
  parameter int OPW   = 22,
  parameter int SELW  = 4,
  parameter int OPCW  = 6,
  parameter int SEL_A   = 1,
  parameter int SEL_B   = 2,
  parameter int SEL_RES = 3,
  parameter int SEL_OP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [SELW-1:0] bus_sel,
  input  logic [DW-1:0]   bus_din,
  output logic [DW-1:0]   bus_dout
);

  localparam int NSEG = (OPW + DW - 1) / DW;
  localparam int IW   = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int TOPW = OPW - (NSEG - 1) * DW;
  localparam logic [DW-1:0] TOP_MASK = ~({DW{1'b1}} << TOPW);
  localparam logic [IW-1:0] LAST_IDX = IW'(NSEG - 1);

  localparam logic [OPCW-1:0] OP_ADD = OPCW'(6'h01);
  localparam logic [OPCW-1:0] OP_SUB = OPCW'(6'h02);
  localparam logic [OPCW-1:0] OP_AND = OPCW'(6'h10);
  localparam logic [OPCW-1:0] OP_OR  = OPCW'(6'h11);
  localparam logic [OPCW-1:0] OP_XOR = OPCW'(6'h12);
  localparam logic [OPCW-1:0] OP_NOT = OPCW'(6'h13);

  logic            s_wr;
  logic [SELW-1:0] s_sel;
  logic [DW-1:0]   s_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_wr  <= 1'b0;
      s_sel <= '0;
      s_din <= '0;
    end else begin
      s_wr  <= bus_wr;
      s_sel <= bus_sel;
      s_din <= bus_din;
    end
  end

  wire wr_a   = s_wr  && (s_sel == SELW'(SEL_A));
  wire wr_b   = s_wr  && (s_sel == SELW'(SEL_B));
  wire wr_op  = s_wr  && (s_sel == SELW'(SEL_OP));
  wire rd_res = !s_wr && (s_sel == SELW'(SEL_RES));

  logic [DW-1:0]   opa, opb;
  logic [OPCW-1:0] opc;
  logic [IW-1:0]   seg_idx;
  logic            cflag;

  wire last_seg = (seg_idx == LAST_IDX);
  wire is_logic = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR) || (opc == OP_NOT);

  wire [DW:0] sum = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cflag};
  wire [DW:0] dif = {1'b0, opa} - {1'b0, opb} - {{DW{1'b0}}, cflag};

  logic [DW-1:0] res_raw;
  logic          cout;

  always_comb begin
    res_raw = '0;
    cout    = 1'b0;
    case (opc)
      OP_ADD: begin res_raw = sum[DW-1:0]; cout = sum[DW]; end
      OP_SUB: begin res_raw = dif[DW-1:0]; cout = dif[DW]; end
      OP_AND: res_raw = opa & opb;
      OP_OR:  res_raw = opa | opb;
      OP_XOR: res_raw = opa ^ opb;
      OP_NOT: res_raw = ~opa;
      default: res_raw = '0;
    endcase
  end

  wire [DW-1:0] res = last_seg ? (res_raw & TOP_MASK) : res_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa <= '0;
      opb <= '0;
    end else begin
      if (wr_a) opa <= s_din;
      if (wr_b) opb <= s_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc      <= '0;
      seg_idx  <= '0;
      cflag    <= 1'b0;
      bus_dout <= '0;
    end else if (wr_op) begin
      opc     <= s_din[OPCW-1:0];
      seg_idx <= '0;
      cflag   <= 1'b0;
    end else if (rd_res) begin
      bus_dout <= res;
      if (last_seg) begin
        seg_idx <= '0;
        cflag   <= 1'b0;
      end else begin
        seg_idx <= seg_idx + IW'(1);
        cflag   <= cout;
      end
    end
  end

  AST_READ_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !s_wr |=> ($stable(opa) && $stable(opb) && $stable(opc))); // R3

  AST_OP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_op |=> (seg_idx == '0 && !cflag)); // R5

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= LAST_IDX); // R10

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !last_seg) |=> (seg_idx == $past(seg_idx) + IW'(1))); // R10

  AST_TOP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && last_seg && !wr_op) |=> ((bus_dout & ~TOP_MASK) == '0)); // R11

  AST_LOGIC_NOCARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && is_logic) |=> !cflag); // R8

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_res |=> $stable(bus_dout)); // R12

endmodule

// File: tb/seg_alu_test.sv
`timescale 1ns/1ps
module seg_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_sel = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d1 = 1'b0, rd_d2 = 1'b0;

  always #2 clk = ~clk;

  seg_alu uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_sel(bus_sel), .bus_din(bus_din), .bus_dout(bus_dout)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rd_d1 <= (bus_sel == 4'd3) && !bus_wr;
    rd_d2 <= rd_d1;
  end

  always @(negedge clk) begin
    if (rd_d2) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual %02h expected none (unexpected result)", bus_dout);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_dout, e);
      end
    end
  end

  task automatic bus(input logic wr, input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_sel = sel; bus_din = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = '0; bus_din = '0;
  endtask

  task automatic seg(input logic [7:0] a, input logic [7:0] b, input logic [7:0] e, input string tag);
    bus(1'b1, 4'd1, a);
    bus(1'b1, 4'd2, b);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(1'b0, 4'd3, 8'h00);
  endtask

  task automatic do_op(input logic [5:0] op, input logic [21:0] a, input logic [21:0] b, input string tag);
    logic [21:0] r;
    logic [23:0] a24, b24, r24;
    case (op)
      6'h01: r = a + b;
      6'h02: r = a - b;
      6'h10: r = a & b;
      6'h11: r = a | b;
      6'h12: r = a ^ b;
      6'h13: r = ~a;
      default: r = '0;
    endcase
    a24 = {2'b11, a};
    b24 = {2'b10, b};
    r24 = {2'b00, r};
    bus(1'b1, 4'd4, {2'b11, op});
    for (int s = 0; s < 3; s++)
      seg(a24[8*s +: 8], b24[8*s +: 8], r24[8*s +: 8], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 dout after reset", bus_dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout after release", bus_dout, 8'h00);

    seg(8'h5a, 8'h33, 8'h00, "R9 R1 reset function code");

    do_op(6'h01, 22'h12_34_56, 22'h01_02_03, "R6 add no carry");
    do_op(6'h01, 22'h00_ff_ff, 22'h00_00_01, "R6 add carry ripple");
    do_op(6'h01, 22'h3f_ff_ff, 22'h00_00_01, "R6 R11 add overflow wraps");
    do_op(6'h02, 22'h10_00_00, 22'h00_00_01, "R7 sub borrow ripple");
    do_op(6'h02, 22'h00_00_00, 22'h00_00_01, "R7 R11 sub underflow");
    do_op(6'h02, 22'h2a_bc_de, 22'h11_22_33, "R7 sub plain");
    do_op(6'h10, 22'h3c_f0_ff, 22'h2a_ff_0f, "R8 and");
    do_op(6'h11, 22'h01_80_00, 22'h20_01_ff, "R8 or");
    do_op(6'h12, 22'h3f_ff_ff, 22'h15_aa_55, "R8 xor");
    do_op(6'h13, 22'h00_0f_f0, 22'h3f_ff_ff, "R8 R11 not");
    do_op(6'h3e, 22'h12_34_56, 22'h0a_0b_0c, "R9 unknown code");

    bus(1'b1, 4'd4, 8'h01);
    seg(8'hff, 8'h01, 8'h00, "R6 wrap seg0");
    seg(8'h00, 8'h00, 8'h01, "R6 wrap seg1 carry in");
    seg(8'hff, 8'h01, 8'h00, "R11 wrap seg2");
    seg(8'h00, 8'h00, 8'h00, "R10 carry cleared on wrap");
    seg(8'hff, 8'hff, 8'hfe, "R10 index restarts unmasked");

    bus(1'b1, 4'd4, 8'h10);
    bus(1'b1, 4'd1, 8'hf0);
    bus(1'b1, 4'd2, 8'h3c);
    bus(1'b0, 4'd1, 8'h00);
    bus(1'b0, 4'd2, 8'h00);
    bus(1'b0, 4'd4, 8'h01);
    exp_q.push_back(8'h30);
    tag_q.push_back("R3 R2 read-line strobes ignored");
    bus(1'b0, 4'd3, 8'h00);

    bus(1'b1, 4'd4, 8'h13);
    bus(1'b1, 4'd1, 8'h0f);
    repeat (3) @(negedge clk);
    held = bus_dout;
    @(negedge clk);
    exp_q.push_back(8'hf0);
    tag_q.push_back("R4 result after two edges");
    bus_wr = 1'b0; bus_sel = 4'd3;
    @(negedge clk);
    bus_sel = '0;
    check("R4 old value after first edge", bus_dout, held);
    repeat (3) @(negedge clk);

    held = bus_dout;
    bus(1'b1, 4'd1, 8'h77);
    bus(1'b1, 4'd2, 8'h88);
    bus(1'b1, 4'd4, 8'h01);
    bus(1'b0, 4'd1, 8'h00);
    repeat (4) @(negedge clk);
    check("R12 dout held", bus_dout, held);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d pending expected 0 pending results", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule